// File: doc/BRIEF.md
# Flash Word Program Command Sequencer

This block is the command front end and status logic of a parallel NOR-style flash memory model, reduced to single-word programming. A host writes command bytes and data over a simple bus whose write strobe is edge-sensitive: each low-to-high transition of the strobe is one bus write. A program operation takes two such writes. The first is a setup command. The second carries the target word address and the new data.

When the second write arrives, the block checks the lock bit of the addressed block and the programming-voltage-valid input. If both checks pass, it holds a busy state for a fixed number of cycles and then writes the bitwise AND of the stored word and the new word into its internal array. It then runs a verify step on the result. A fault-injection input can force one bit of the stored result to 1, which exercises the verify path. The outcome of each operation is held in a status register. Reads return that register from the setup command onward, until the host switches back to array reads.

Top module: `flashWordProg`

## Requirements
- R1: After reset, `readyOut` is 1, reads return array contents, every array word reads as all ones, and status reads 0x80.
- R2: A program sequence is a write whose low byte is 0x40 or 0x10, followed by a second write that supplies the address and data. A write is taken once per rising edge of `busWe`, however long the strobe is held high.
- R3: From the setup write onward, reads return the status byte in bits 7:0 with the upper bits zero. This continues until a write of 0xFF, which returns reads to array contents.
- R4: After an accepted data write, `readyOut` is low for exactly PROG_CYCLES cycles. Status bit 7 reads as the value of `readyOut`.
- R5: The block index is the top BLOCK_BITS bits of the address. If the addressed block's bit in `lockBits` is set, status bits 1 and 4 are set, the array is unchanged, and the block does not go busy.
- R6: If `vppOk` is low at the data write, status bits 3 and 4 are set, the array is unchanged, and the block does not go busy.
- R7: A successful program leaves (old word AND new data) at the address, so programming can only clear bits.
- R8: Status bit 4 is set after a program only if the stored word holds a 1 where (old AND new) holds a 0. When `faultEn` is high, bit `faultBit` of the stored word is forced to 1.
- R9: Status bits 1, 3 and 4 stay set until a write of 0x50 clears them.
- R10: Bus writes made while the block is busy have no effect on the mode, the status or the array.
- R11: A write in the idle state whose low byte is not 0x40, 0x10, 0x50 or 0xFF is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe; each rising edge is one bus write |
| busAddr | input | ADDR_W | Word address for writes and reads |
| busDin | input | DATA_W | Write data; command byte in bits 7:0 |
| busRdData | output | DATA_W | Read data: status byte or array word, by mode |
| vppOk | input | 1 | Programming voltage valid |
| lockBits | input | 2**BLOCK_BITS | Per-block lock bits |
| faultEn | input | 1 | Enables the forced stuck-at-1 bit |
| faultBit | input | $clog2(DATA_W) | Bit position forced to 1 |
| readyOut | output | 1 | High when no program operation is running |

## Verification
The assertions check these rules on every cycle: status bit 7 reads as `readyOut`, a lock or voltage abort returns ready with the right error bits set on the next cycle, busy periods last exactly PROG_CYCLES, the error bits clear only after a clear-status write, and the read mode holds steady while the block is busy. The array contents after AND-only programming, the verify outcome under an injected fault, the edge-only capture of a held strobe, and the handling of unknown commands are shown only by the bench. It drives those scenarios and compares reads against its own model of the array.

// File: rtl/flashProgPkg.sv
package flashProgPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_BUSY  = 2'd2
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureEn;   // data write accepted in setup state
    logic commitEn;    // last busy cycle: write result into array
    logic statusMode;  // reads return status byte
    logic clearErr;    // clear-status command seen
    logic busy;        // program operation running
  } ctrlStrb_t;

  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT = 8'h10;
  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_RD_ARRAY = 8'hFF;

  localparam int SR_READY    = 7;
  localparam int SR_PROG_ERR = 4;
  localparam int SR_VPP_ERR  = 3;
  localparam int SR_LOCK_ERR = 1;

endpackage

// File: rtl/flashProgCtrl.sv
module flashProgCtrl
  import flashProgPkg::*;
#(
  parameter int PROG_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWe,
  input  logic [7:0] cmdByte,
  input  logic       lockHit,
  input  logic       vppOk,
  input  logic       verifyFail,
  output ctrlStrb_t  strb,
  output logic [7:0] statusReg
);

  localparam int CNT_W = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

  ctrlState_e       state;
  logic [CNT_W-1:0] cnt;
  logic             weQ;
  logic             weRise;
  logic             statusMode;
  logic             errLock;
  logic             errVpp;
  logic             errProg;
  logic             startProg;
  logic             isProgCmd;

  assign weRise    = busWe & ~weQ;
  assign isProgCmd = (cmdByte == CMD_PROG) || (cmdByte == CMD_PROG_ALT);
  assign startProg = weRise && (state == ST_SETUP) && !lockHit && vppOk;

  always_comb begin
    strb.captureEn  = weRise && (state == ST_SETUP);
    strb.commitEn   = (state == ST_BUSY) && (cnt == '0);
    strb.statusMode = statusMode;
    strb.clearErr   = weRise && (state == ST_IDLE) && (cmdByte == CMD_CLR_STAT);
    strb.busy       = (state == ST_BUSY);
  end

  always_comb begin
    statusReg              = '0;
    statusReg[SR_READY]    = (state != ST_BUSY);
    statusReg[SR_PROG_ERR] = errProg;
    statusReg[SR_VPP_ERR]  = errVpp;
    statusReg[SR_LOCK_ERR] = errLock;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weQ <= 1'b0;
    end else begin
      weQ <= busWe;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      statusMode <= 1'b0;
      errLock    <= 1'b0;
      errVpp     <= 1'b0;
      errProg    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (weRise) begin
            if (isProgCmd) begin
              state      <= ST_SETUP;
              statusMode <= 1'b1;
            end else if (cmdByte == CMD_CLR_STAT) begin
              errLock <= 1'b0;
              errVpp  <= 1'b0;
              errProg <= 1'b0;
            end else if (cmdByte == CMD_RD_ARRAY) begin
              statusMode <= 1'b0;
            end
          end
        end
        ST_SETUP: begin
          if (weRise) begin
            if (lockHit) begin
              errLock <= 1'b1;
              errProg <= 1'b1;
            end
            if (!vppOk) begin
              errVpp  <= 1'b1;
              errProg <= 1'b1;
            end
            if (startProg) begin
              state <= ST_BUSY;
              cnt   <= CNT_LOAD;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_BUSY: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
            if (verifyFail) errProg <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flashProgDatapath.sv
module flashProgDatapath
  import flashProgPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 6,
  parameter int BLOCK_BITS = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrb_t                 strb,
  input  logic [ADDR_W-1:0]         busAddr,
  input  logic [DATA_W-1:0]         busDin,
  input  logic [(1<<BLOCK_BITS)-1:0] lockBits,
  input  logic                      faultEn,
  input  logic [$clog2(DATA_W)-1:0] faultBit,
  input  logic [7:0]                statusReg,
  output logic                      lockHit,
  output logic                      verifyFail,
  output logic [DATA_W-1:0]         busRdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] capAddr;
  logic [DATA_W-1:0] capData;
  logic [DATA_W-1:0] oldWord;
  logic [DATA_W-1:0] targetWord;
  logic [DATA_W-1:0] faultMask;
  logic [DATA_W-1:0] storedWord;

  assign lockHit    = lockBits[busAddr[ADDR_W-1 -: BLOCK_BITS]];
  assign oldWord    = mem[capAddr];
  assign targetWord = oldWord & capData;
  assign faultMask  = faultEn ? (DATA_W'(1) << faultBit) : '0;
  assign storedWord = targetWord | faultMask;
  assign verifyFail = |(storedWord & ~targetWord);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capAddr <= '0;
      capData <= '0;
    end else if (strb.captureEn) begin
      capAddr <= busAddr;
      capData <= busDin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strb.commitEn) begin
      mem[capAddr] <= storedWord;
    end
  end

  always_comb begin
    if (strb.statusMode) busRdData = {{(DATA_W-8){1'b0}}, statusReg};
    else                 busRdData = mem[busAddr];
  end

endmodule

// File: rtl/flashWordProg.sv
module flashWordProg
  import flashProgPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 6,
  parameter int BLOCK_BITS  = 2,
  parameter int PROG_CYCLES = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWe,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busDin,
  output logic [DATA_W-1:0]          busRdData,
  input  logic                       vppOk,
  input  logic [(1<<BLOCK_BITS)-1:0] lockBits,
  input  logic                       faultEn,
  input  logic [$clog2(DATA_W)-1:0]  faultBit,
  output logic                       readyOut
);

  ctrlStrb_t  strb;
  logic [7:0] statusReg;
  logic       lockHit;
  logic       verifyFail;

  flashProgCtrl #(.PROG_CYCLES(PROG_CYCLES)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWe      (busWe),
    .cmdByte    (busDin[7:0]),
    .lockHit    (lockHit),
    .vppOk      (vppOk),
    .verifyFail (verifyFail),
    .strb       (strb),
    .statusReg  (statusReg)
  );

  flashProgDatapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLOCK_BITS(BLOCK_BITS)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busAddr    (busAddr),
    .busDin     (busDin),
    .lockBits   (lockBits),
    .faultEn    (faultEn),
    .faultBit   (faultBit),
    .statusReg  (statusReg),
    .lockHit    (lockHit),
    .verifyFail (verifyFail),
    .busRdData  (busRdData)
  );

  assign readyOut = ~strb.busy;

endmodule

// File: rtl/flashWordProgChk.sv
module flashWordProgChk #(
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              readyOut,
  input logic [DATA_W-1:0] busRdData,
  input logic              statusMode,
  input logic [7:0]        statusReg,
  input logic              captureEn,
  input logic              lockHit,
  input logic              vppOk,
  input logic              clearErr
);

  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)         busyRun <= 0;
    else if (!readyOut) busyRun <= busyRun + 1;
    else               busyRun <= 0;
  end

  // R4: status bit 7 seen on the bus follows the ready pin
  a_r4_ready_mirror: assert property (@(posedge clk) disable iff (!rstN)
    statusMode |-> (busRdData[7] == readyOut));

  // R4: busy lasts exactly PROG_CYCLES
  a_r4_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyOut) |-> (busyRun == PROG_CYCLES));

  // R5: locked target aborts at once
  a_r5_lock_abort: assert property (@(posedge clk) disable iff (!rstN)
    (captureEn && lockHit) |=> (readyOut && statusReg[1] && statusReg[4]));

  // R6: low programming voltage aborts at once
  a_r6_vpp_abort: assert property (@(posedge clk) disable iff (!rstN)
    (captureEn && !vppOk) |=> (readyOut && statusReg[3] && statusReg[4]));

  // R9: error bits fall only after a clear-status write
  a_r9_sticky_prog: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusReg[4]) |-> $past(clearErr));
  a_r9_sticky_lock: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusReg[1]) |-> $past(clearErr));
  a_r9_sticky_vpp: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusReg[3]) |-> $past(clearErr));

  // R10: read mode does not move while busy
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !readyOut |=> $stable(statusMode));

endmodule

bind flashWordProg flashWordProgChk #(
  .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)
) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .readyOut   (readyOut),
  .busRdData  (busRdData),
  .statusMode (strb.statusMode),
  .statusReg  (statusReg),
  .captureEn  (strb.captureEn),
  .lockHit    (lockHit),
  .vppOk      (vppOk),
  .clearErr   (strb.clearErr)
);

// File: tb/test_flashWordProg.sv
`timescale 1ns/1ps
module test_flashWordProg;

  localparam int DW = 16;
  localparam int AW = 6;
  localparam int BB = 2;
  localparam int PC = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busDin = '0;
  logic [DW-1:0] busRdData;
  logic          vppOk = 1'b1;
  logic [3:0]    lockBits = '0;
  logic          faultEn = 1'b0;
  logic [3:0]    faultBit = '0;
  logic          readyOut;
  logic          rdStrobe = 1'b0;

  int applied = 0;
  int miscompares = 0;
  bit done = 0;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } sbItem_t;
  sbItem_t sbQ[$];

  always #4 clk = ~clk;

  flashWordProg #(.DATA_W(DW), .ADDR_W(AW), .BLOCK_BITS(BB), .PROG_CYCLES(PC)) i_flashWordProg (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busDin(busDin),
    .busRdData(busRdData), .vppOk(vppOk), .lockBits(lockBits), .faultEn(faultEn),
    .faultBit(faultBit), .readyOut(readyOut)
  );

  task automatic checkVal(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  // monitor: pops expected reads from the scoreboard
  always @(negedge clk) begin
    if (rdStrobe) begin
      if (sbQ.size() == 0) begin
        applied++; miscompares++;
        $display("FAIL scoreboard: actual %h expected none", busRdData);
      end else begin
        sbItem_t it;
        it = sbQ.pop_front();
        checkVal(busRdData, it.exp, it.tag);
      end
    end
  end

  task automatic expectRead(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    sbItem_t it;
    it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    @(posedge clk); #1 busAddr = a; rdStrobe = 1'b1;
    @(posedge clk); #1 rdStrobe = 1'b0;
  endtask

  // strobe held across two edges: only the rising edge may count (R2)
  task automatic busWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1 busWe = 1'b1; busAddr = a; busDin = d;
    @(posedge clk); #1;
    @(posedge clk); #1 busWe = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic dataWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1 busWe = 1'b1; busAddr = a; busDin = d;
    @(posedge clk); #1 busWe = 1'b0;
  endtask

  task automatic doProgram(input logic [7:0] cmd, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input int expBusy, input string tag);
    int n;
    busWrite('0, {8'h00, cmd});
    dataWrite(a, d);
    n = 0;
    forever begin
      @(negedge clk);
      if (readyOut) break;
      if (n == 0) checkVal({15'b0, busRdData[7]}, 16'h0, "R4 status bit7 low while busy");
      n++;
      if (n > 1000) break;
    end
    checkVal(DW'(n), DW'(expBusy), tag);
  endtask

  task automatic waitReady();
    int n;
    n = 0;
    while (!readyOut && n < 1000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      applied++; miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    checkVal({15'b0, readyOut}, 16'h1, "R1 ready after reset");
    expectRead(0, 16'hFFFF, "R1 erased word 0");
    expectRead(63, 16'hFFFF, "R1 erased word 63");

    // basic program, primary setup code
    doProgram(8'h40, 3, 16'h1234, PC, "R4 busy length");
    expectRead(0, 16'h0080, "R3 status read after program");
    busWrite(0, 16'h00FF);
    expectRead(3, 16'h1234, "R7 programmed word");
    expectRead(4, 16'hFFFF, "R3 array mode restored");

    // alternate setup code, AND with old contents, no false error
    doProgram(8'h10, 3, 16'hFF0F, PC, "R2 alt setup busy");
    expectRead(0, 16'h0080, "R8 no error on 0->1 request");
    busWrite(0, 16'h00FF);
    expectRead(3, 16'h1204, "R7 AND-only result");

    // lock abort
    lockBits = 4'b0100;
    doProgram(8'h40, 6'h25, 16'h0000, 0, "R5 no busy on lock");
    expectRead(0, 16'h0092, "R5 lock error bits");
    busWrite(0, 16'h0033);
    expectRead(0, 16'h0092, "R11 unknown cmd ignored, R9 sticky");
    busWrite(0, 16'h0050);
    expectRead(0, 16'h0080, "R9 clear status");
    busWrite(0, 16'h00FF);
    expectRead(6'h25, 16'hFFFF, "R5 array unchanged");
    lockBits = '0;

    // low programming voltage
    vppOk = 1'b0;
    doProgram(8'h40, 8, 16'h0000, 0, "R6 no busy on low voltage");
    expectRead(0, 16'h0098, "R6 voltage error bits");
    busWrite(0, 16'h0050);
    busWrite(0, 16'h00FF);
    expectRead(8, 16'hFFFF, "R6 array unchanged");
    vppOk = 1'b1;

    // injected stuck-at-1 on a bit that should clear
    faultEn = 1'b1; faultBit = 4'd0;
    doProgram(8'h40, 5, 16'hFFFE, PC, "R8 busy with fault");
    expectRead(0, 16'h0090, "R8 verify error");
    busWrite(0, 16'h0050);
    busWrite(0, 16'h00FF);
    expectRead(5, 16'hFFFF, "R8 stuck bit stored");

    // injected stuck-at-1 on a bit that stays 1 anyway
    faultBit = 4'd15;
    doProgram(8'h40, 6, 16'h8000, PC, "R8 busy benign fault");
    expectRead(0, 16'h0080, "R8 no error when target bit is 1");
    busWrite(0, 16'h00FF);
    expectRead(6, 16'h8000, "R7 result with benign fault");
    faultEn = 1'b0;

    // writes during busy are ignored
    busWrite(0, 16'h0040);
    dataWrite(10, 16'h00F0);
    busWrite(0, 16'h00FF);
    busWrite(0, 16'h0050);
    waitReady();
    expectRead(10, 16'h0080, "R10 mode kept through busy writes");
    busWrite(0, 16'h00FF);
    expectRead(10, 16'h00F0, "R10 program completed");

    repeat (2) @(posedge clk);
    if (sbQ.size() != 0) begin
      applied++; miscompares++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sbQ.size());
    end
    done = 1;
    finishRun();
  end

endmodule